// File: doc/BRIEF.md
# Sensor Code Calibration Converter

This block maps between raw 8-bit thermal sensor codes and signed Celsius values. The mapping uses two per-part calibration codes. When the load strobe is pulsed, the block captures a 32-bit factory trim word and takes both codes from it. A code that is absent or implausible is replaced by the matching byte of a built-in default fuse word.

Requests arrive on a valid/ready handshake. A direction bit picks the conversion:

- temperature to code, or
- code to temperature.

A two-bit mode input picks how the conversion is done:

- linear interpolation between two calibration points,
- a single-point offset, or
- a fixed offset when no trim is used.

All modes share one serial divider, so every answer arrives after the same latency. The result is signed. An error flag marks a division by zero and, when the range-limit input is set, an out-of-range operand. An errored result reads zero.

Top module: `thermcal_conv`

## Requirements
- R1: After reset, req_ready is 1 and rsp_valid is 0. The calibration codes hold the default fuse bytes: E1 = 55 (bits 7:0 of the default word 0x00007337) and E2 = 115 (bits 15:8).
- R2: On a cycle with trim_load high, E1 takes trim_word[7:0]. If that byte is zero, below 40 or above 100, E1 takes 55 instead.
- R3: On a cycle with trim_load high, E2 takes trim_word[15:8]. If that byte is zero, E2 takes 115 instead.
- R4: With cal_mode 2'b10 and req_dir 0, the result is (T−25)·(E2−E1)/60 + E1, where T is req_value.
- R5: With cal_mode 2'b10 and req_dir 1, the result is (C−E1)·60/(E2−E1) + 25, where C is req_value. Every division truncates toward zero, including for negative quotients.
- R6: With cal_mode 2'b01, the result is T + E1 − 25 for req_dir 0 and C − E1 + 25 for req_dir 1.
- R7: With cal_mode 2'b00 or 2'b11, the result is T + 50 for req_dir 0 and C − 50 for req_dir 1.
- R8: With range_lim high, rsp_err is 1 and the result is 0 in two cases: req_dir 0 with req_value outside 25..125, or req_dir 1 with req_value outside 75..175. The bounds are inclusive.
- R9: If the divisor is zero (E2 equal to E1 in R5), rsp_err is 1 and rsp_value is 0.
- R10: rsp_valid is high for exactly one cycle, following the 17th rising clock edge after the accepting edge. req_ready is low from the accepting edge until that response cycle.
- R11: A request's operands and calibration codes are fixed at acceptance. A trim_load while a request is in flight does not change that request's result. It does change the results of later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trim_load | input | 1 | Capture trim_word into the calibration codes |
| trim_word | input | 32 | Factory trim word |
| cal_mode | input | 2 | 00/11 no trim, 01 one-point, 10 two-point |
| range_lim | input | 1 | Enable the legacy operand range check |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block can accept a request |
| req_dir | input | 1 | 0 temperature to code, 1 code to temperature |
| req_value | input | 8 | Temperature or code operand |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_err | output | 1 | Division by zero or range violation |
| rsp_value | output | 18 | Signed result, zero on error |

## Verification
The hardest situation to reach is a trim reload that lands while a division is still running. Only the request's response shows its effect. The stimulus pulses trim_load a few cycles after acceptance and checks two results: the in-flight answer must still use the old codes, and the next answer must use the new ones. Random requests also mix reloads with all modes. Directed cases cover the window edges of the E1 fallback, equal trim codes, negative quotients that truncate toward zero, and the inclusive range bounds.

// File: rtl/thermcal_pkg.sv
package thermcal_pkg;
  typedef enum logic [1:0] {
    CAL_NONE = 2'b00,
    CAL_ONE  = 2'b01,
    CAL_TWO  = 2'b10,
    CAL_RSVD = 2'b11
  } cal_mode_e;
endpackage

// File: rtl/thermcal_trim.sv
module thermcal_trim #(
  parameter int CODE_W = 8,
  parameter int TRIM_W = 32,
  parameter int E2_SHIFT = 8,
  parameter logic [TRIM_W-1:0] DEF_FUSE = 32'h0000_7337,
  parameter int FUSE_MIN = 40,
  parameter int FUSE_MAX = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CODE_W-1:0] raw_lo,
  input  logic [CODE_W-1:0] raw_hi,
  output logic [CODE_W-1:0] e1,
  output logic [CODE_W-1:0] e2
);
  localparam logic [CODE_W-1:0] DEF_E1 = DEF_FUSE[CODE_W-1:0];
  localparam logic [CODE_W-1:0] DEF_E2 = DEF_FUSE[E2_SHIFT +: CODE_W];
  localparam logic [CODE_W-1:0] WIN_LO = CODE_W'(FUSE_MIN);
  localparam logic [CODE_W-1:0] WIN_HI = CODE_W'(FUSE_MAX);

  logic [CODE_W-1:0] e1_d, e1_q, e2_d, e2_q;
  logic              lo_bad, hi_bad;

  always_comb begin
    lo_bad = (raw_lo == '0) || (raw_lo < WIN_LO) || (raw_lo > WIN_HI);
    hi_bad = (raw_hi == '0);
    e1_d   = lo_bad ? DEF_E1 : raw_lo;
    e2_d   = hi_bad ? DEF_E2 : raw_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e1_q <= DEF_E1;
      e2_q <= DEF_E2;
    end else if (load) begin
      e1_q <= e1_d;
      e2_q <= e2_d;
    end
  end

  assign e1 = e1_q;
  assign e2 = e2_q;
endmodule

// File: rtl/thermcal_operand.sv
module thermcal_operand
  import thermcal_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int P1_TEMP = 25,
  parameter int P2_TEMP = 85,
  parameter int NOTRIM_OFS = 50,
  parameter int LIM_TLO = 25,
  parameter int LIM_THI = 125,
  parameter int LIM_CLO = 75,
  parameter int LIM_CHI = 175,
  localparam int OP_W = CODE_W + 2,
  localparam int NUM_W = 2 * CODE_W,
  localparam int DVS_W = CODE_W + 1
) (
  input  logic [1:0]             mode,
  input  logic                   dir,
  input  logic                   range_lim,
  input  logic [CODE_W-1:0]      value,
  input  logic [CODE_W-1:0]      e1,
  input  logic [CODE_W-1:0]      e2,
  output logic [NUM_W-1:0]       dvd,
  output logic [DVS_W-1:0]       dvs,
  output logic                   neg,
  output logic signed [OP_W-1:0] add,
  output logic                   err
);
  localparam int PROD_W = 2 * OP_W;
  localparam logic signed [OP_W-1:0] P1_S = OP_W'(P1_TEMP);
  localparam logic signed [OP_W-1:0] SPAN_S = OP_W'(P2_TEMP - P1_TEMP);
  localparam logic signed [OP_W-1:0] OFS_S = OP_W'(NOTRIM_OFS);
  localparam logic signed [OP_W-1:0] ONE_S = OP_W'(1);
  localparam logic [CODE_W-1:0] TLO = CODE_W'(LIM_TLO);
  localparam logic [CODE_W-1:0] THI = CODE_W'(LIM_THI);
  localparam logic [CODE_W-1:0] CLO = CODE_W'(LIM_CLO);
  localparam logic [CODE_W-1:0] CHI = CODE_W'(LIM_CHI);

  logic signed [OP_W-1:0]   x, e1s, e2s, base, mul, den, diff, dmag;
  logic signed [PROD_W-1:0] prod, pmag;
  logic                     out_of_range;
  logic                     unused_mag_bits;

  always_comb begin
    x    = signed'({2'b00, value});
    e1s  = signed'({2'b00, e1});
    e2s  = signed'({2'b00, e2});
    base = '0;
    mul  = ONE_S;
    den  = ONE_S;
    add  = '0;
    unique case (cal_mode_e'(mode))
      CAL_TWO: begin
        if (!dir) begin
          base = P1_S; mul = e2s - e1s; den = SPAN_S; add = e1s;
        end else begin
          base = e1s; mul = SPAN_S; den = e2s - e1s; add = P1_S;
        end
      end
      CAL_ONE: begin
        if (!dir) begin base = P1_S; add = e1s; end
        else      begin base = e1s;  add = P1_S; end
      end
      default: begin
        if (!dir) add = OFS_S;
        else      base = OFS_S;
      end
    endcase
    diff = x - base;
    prod = PROD_W'(diff) * PROD_W'(mul);
    pmag = prod[PROD_W-1] ? -prod : prod;
    dmag = den[OP_W-1] ? -den : den;
    dvd  = pmag[NUM_W-1:0];
    dvs  = dmag[DVS_W-1:0];
    neg  = prod[PROD_W-1] ^ den[OP_W-1];
    out_of_range = dir ? ((value < CLO) || (value > CHI))
                       : ((value < TLO) || (value > THI));
    err  = (range_lim && out_of_range) || (den == '0);
  end

  assign unused_mag_bits = ^{pmag[PROD_W-1:NUM_W], dmag[OP_W-1]};
endmodule

// File: rtl/thermcal_div.sv
module thermcal_div #(
  parameter int NUM_W = 16,
  parameter int DVS_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] dvd,
  input  logic [DVS_W-1:0] dvs,
  output logic             done,
  output logic [NUM_W-1:0] quo
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic             run_d, run_q, done_d, done_q;
  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic [DVS_W-1:0] rem_d, rem_q, dvs_d, dvs_q;
  logic [NUM_W-1:0] quo_d, quo_q;
  logic [DVS_W:0]   shifted, trial;
  logic             fits;

  always_comb begin
    shifted = {rem_q, quo_q[NUM_W-1]};
    trial   = shifted - {1'b0, dvs_q};
    fits    = shifted >= {1'b0, dvs_q};
    run_d   = run_q;
    cnt_d   = cnt_q;
    rem_d   = rem_q;
    quo_d   = quo_q;
    dvs_d   = dvs_q;
    done_d  = 1'b0;
    if (start) begin
      run_d = 1'b1;
      cnt_d = CNT_W'(NUM_W);
      rem_d = '0;
      quo_d = dvd;
      dvs_d = dvs;
    end else if (run_q) begin
      rem_d = fits ? trial[DVS_W-1:0] : shifted[DVS_W-1:0];
      quo_d = {quo_q[NUM_W-2:0], fits};
      cnt_d = cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
    end else begin
      run_q  <= run_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      dvs_q  <= dvs_d;
    end
  end

  assign done = done_q;
  assign quo  = quo_q;
endmodule

// File: rtl/thermcal_conv.sv
module thermcal_conv #(
  parameter int CODE_W = 8,
  parameter int TRIM_W = 32,
  parameter int E2_SHIFT = 8,
  parameter logic [TRIM_W-1:0] DEF_FUSE = 32'h0000_7337,
  parameter int FUSE_MIN = 40,
  parameter int FUSE_MAX = 100,
  parameter int P1_TEMP = 25,
  parameter int P2_TEMP = 85,
  parameter int NOTRIM_OFS = 50,
  parameter int LIM_TLO = 25,
  parameter int LIM_THI = 125,
  parameter int LIM_CLO = 75,
  parameter int LIM_CHI = 175
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       trim_load,
  input  logic [TRIM_W-1:0]          trim_word,
  input  logic [1:0]                 cal_mode,
  input  logic                       range_lim,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_dir,
  input  logic [CODE_W-1:0]          req_value,
  output logic                       rsp_valid,
  output logic                       rsp_err,
  output logic signed [2*CODE_W+1:0] rsp_value
);
  localparam int OP_W  = CODE_W + 2;
  localparam int NUM_W = 2 * CODE_W;
  localparam int DVS_W = CODE_W + 1;
  localparam int RES_W = NUM_W + 2;

  logic [CODE_W-1:0]       e1, e2;
  logic [NUM_W-1:0]        op_dvd, quo;
  logic [DVS_W-1:0]        op_dvs;
  logic                    op_neg, op_err, accept, div_done;
  logic signed [OP_W-1:0]  op_add;
  logic                    busy_d, busy_q, sign_d, sign_q, err_d, err_q;
  logic signed [OP_W-1:0]  add_d, add_q;
  logic                    vld_d, vld_q, rerr_d, rerr_q;
  logic signed [RES_W-1:0] res_d, res_q, qs;
  logic                    unused_trim_bits;

  assign unused_trim_bits = ^trim_word;

  thermcal_trim #(
    .CODE_W(CODE_W), .TRIM_W(TRIM_W), .E2_SHIFT(E2_SHIFT),
    .DEF_FUSE(DEF_FUSE), .FUSE_MIN(FUSE_MIN), .FUSE_MAX(FUSE_MAX)
  ) u_trim (
    .clk(clk), .rst_n(rst_n), .load(trim_load),
    .raw_lo(trim_word[CODE_W-1:0]), .raw_hi(trim_word[E2_SHIFT +: CODE_W]),
    .e1(e1), .e2(e2)
  );

  thermcal_operand #(
    .CODE_W(CODE_W), .P1_TEMP(P1_TEMP), .P2_TEMP(P2_TEMP),
    .NOTRIM_OFS(NOTRIM_OFS), .LIM_TLO(LIM_TLO), .LIM_THI(LIM_THI),
    .LIM_CLO(LIM_CLO), .LIM_CHI(LIM_CHI)
  ) u_op (
    .mode(cal_mode), .dir(req_dir), .range_lim(range_lim), .value(req_value),
    .e1(e1), .e2(e2), .dvd(op_dvd), .dvs(op_dvs), .neg(op_neg),
    .add(op_add), .err(op_err)
  );

  thermcal_div #(.NUM_W(NUM_W), .DVS_W(DVS_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(accept), .dvd(op_dvd), .dvs(op_dvs),
    .done(div_done), .quo(quo)
  );

  assign accept = req_valid && !busy_q;

  always_comb begin
    busy_d = busy_q;
    sign_d = sign_q;
    err_d  = err_q;
    add_d  = add_q;
    vld_d  = 1'b0;
    rerr_d = rerr_q;
    res_d  = res_q;
    qs     = signed'({2'b00, quo});
    if (div_done) begin
      busy_d = 1'b0;
      vld_d  = 1'b1;
      rerr_d = err_q;
      res_d  = err_q ? '0 : ((sign_q ? -qs : qs) + RES_W'(add_q));
    end
    if (accept) begin
      busy_d = 1'b1;
      sign_d = op_neg;
      err_d  = op_err;
      add_d  = op_add;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sign_q <= 1'b0;
      err_q  <= 1'b0;
      add_q  <= '0;
      vld_q  <= 1'b0;
      rerr_q <= 1'b0;
      res_q  <= '0;
    end else begin
      busy_q <= busy_d;
      sign_q <= sign_d;
      err_q  <= err_d;
      add_q  <= add_d;
      vld_q  <= vld_d;
      rerr_q <= rerr_d;
      res_q  <= res_d;
    end
  end

  assign req_ready = !busy_q;
  assign rsp_valid = vld_q;
  assign rsp_err   = rerr_q;
  assign rsp_value = res_q;
endmodule

// File: rtl/thermcal_conv_chk.sv
module thermcal_conv_chk #(
  parameter int CODE_W = 8,
  parameter int LIM_TLO = 25,
  parameter int LIM_THI = 125,
  parameter int LIM_CLO = 75,
  parameter int LIM_CHI = 175
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_valid,
  input logic                       req_ready,
  input logic                       req_dir,
  input logic [CODE_W-1:0]          req_value,
  input logic                       range_lim,
  input logic                       rsp_valid,
  input logic                       rsp_err,
  input logic signed [2*CODE_W+1:0] rsp_value
);
  localparam int LAT = 2 * CODE_W + 1;

  logic       inflight_q, rng_q;
  logic [7:0] cnt_q;
  logic       take, rng_now;

  assign take    = req_valid && req_ready;
  assign rng_now = range_lim && (req_dir ?
                   ((req_value < CODE_W'(LIM_CLO)) || (req_value > CODE_W'(LIM_CHI))) :
                   ((req_value < CODE_W'(LIM_TLO)) || (req_value > CODE_W'(LIM_THI))));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inflight_q <= 1'b0;
      rng_q      <= 1'b0;
      cnt_q      <= '0;
    end else if (take) begin
      inflight_q <= 1'b1;
      rng_q      <= rng_now;
      cnt_q      <= '0;
    end else if (rsp_valid) begin
      inflight_q <= 1'b0;
    end else if (inflight_q) begin
      cnt_q <= cnt_q + 8'd1;
    end
  end

  assert_ready_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !req_ready);
  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (inflight_q && cnt_q == 8'(LAT)));
  assert_ready_rises_with_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |-> rsp_valid);
  assert_err_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_value == '0));
  assert_range_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rng_q) |-> rsp_err);
endmodule

bind thermcal_conv thermcal_conv_chk #(
  .CODE_W(CODE_W), .LIM_TLO(LIM_TLO), .LIM_THI(LIM_THI),
  .LIM_CLO(LIM_CLO), .LIM_CHI(LIM_CHI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_dir(req_dir), .req_value(req_value), .range_lim(range_lim),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_value(rsp_value)
);

// File: tb/thermcal_conv_test.sv
`timescale 1ns/1ps
module thermcal_conv_test;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               trim_load = 1'b0;
  logic [31:0]        trim_word = '0;
  logic [1:0]         cal_mode = '0;
  logic               range_lim = 1'b0;
  logic               req_valid = 1'b0;
  logic               req_ready;
  logic               req_dir = 1'b0;
  logic [7:0]         req_value = '0;
  logic               rsp_valid;
  logic               rsp_err;
  logic signed [17:0] rsp_value;

  int tests = 0;
  int fails = 0;
  int cur_e1 = 55;
  int cur_e2 = 115;

  always #2 clk = ~clk;

  thermcal_conv uut (
    .clk(clk), .rst_n(rst_n), .trim_load(trim_load), .trim_word(trim_word),
    .cal_mode(cal_mode), .range_lim(range_lim), .req_valid(req_valid),
    .req_ready(req_ready), .req_dir(req_dir), .req_value(req_value),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_value(rsp_value)
  );

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int fb_e1(input logic [31:0] w);
    int b = int'(w[7:0]);
    return (b == 0 || b < 40 || b > 100) ? 55 : b;
  endfunction

  function automatic int fb_e2(input logic [31:0] w);
    int b = int'(w[15:8]);
    return (b == 0) ? 115 : b;
  endfunction

  function automatic void ref_conv(input int mode, input int dir, input int v,
                                   input int rl, input int e1, input int e2,
                                   output int err, output int res);
    err = 0;
    res = 0;
    if (rl != 0 && ((dir == 0 && (v < 25 || v > 125)) ||
                    (dir == 1 && (v < 75 || v > 175)))) err = 1;
    if (mode == 2) begin
      if (dir == 0) res = (v - 25) * (e2 - e1) / 60 + e1;
      else if (e2 == e1) err = 1;
      else res = (v - e1) * 60 / (e2 - e1) + 25;
    end else if (mode == 1) begin
      res = (dir == 0) ? v + e1 - 25 : v - e1 + 25;
    end else begin
      res = (dir == 0) ? v + 50 : v - 50;
    end
    if (err != 0) res = 0;
  endfunction

  task automatic load_trim(input logic [31:0] w);
    trim_word = w;
    trim_load = 1'b1;
    @(negedge clk);
    trim_load = 1'b0;
    cur_e1 = fb_e1(w);
    cur_e2 = fb_e2(w);
  endtask

  task automatic run_req(input int mode, input int dir, input int v, input int rl,
                         input bit mid, input logic [31:0] mw, input string tag);
    int cyc = 0;
    int ee, er;
    bit rdy_bad = 1'b0;
    ref_conv(mode, dir, v, rl, cur_e1, cur_e2, ee, er);
    cal_mode  = mode[1:0];
    req_dir   = dir[0];
    req_value = v[7:0];
    range_lim = rl[0];
    req_valid = 1'b1;
    do begin
      @(negedge clk);
      cyc++;
      req_valid = 1'b0;
      if (mid && cyc == 3) begin
        trim_word = mw;
        trim_load = 1'b1;
      end else begin
        trim_load = 1'b0;
      end
      if (!rsp_valid && req_ready) rdy_bad = 1'b1;
    end while (!rsp_valid && cyc < 100);
    trim_load = 1'b0;
    if (mid) begin
      cur_e1 = fb_e1(mw);
      cur_e2 = fb_e2(mw);
    end
    check({tag, " err"}, int'(rsp_err), ee);
    check({tag, " value"}, int'(rsp_value), er);
    check("R10 latency", cyc, 18);
    check("R10 ready low while busy", int'(rdy_bad), 0);
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    check("R1 ready in reset", int'(req_ready), 1);
    check("R1 no response in reset", int'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", int'(req_ready), 1);
    check("R1 no response after reset", int'(rsp_valid), 0);
    run_req(1, 0, 25, 0, 0, '0, "R1 default E1");
    run_req(2, 0, 85, 0, 0, '0, "R1 default E2");

    // R2 / R3: fallback windows, observed through conversions
    load_trim(32'h0000_7800);
    run_req(1, 0, 25, 0, 0, '0, "R2 zero E1");
    run_req(2, 0, 85, 0, 0, '0, "R3 E2 kept");
    load_trim(32'h0000_001E);
    run_req(1, 0, 25, 0, 0, '0, "R2 below window");
    run_req(2, 0, 85, 0, 0, '0, "R3 zero E2");
    load_trim(32'h0000_5A65);
    run_req(1, 0, 25, 0, 0, '0, "R2 above window");
    load_trim(32'h0000_5A28);
    run_req(1, 0, 25, 0, 0, '0, "R2 window low edge");
    load_trim(32'h0000_5A64);
    run_req(1, 0, 25, 0, 0, '0, "R2 window high edge");

    // R4 / R5: two-point with E1=50, E2=90
    load_trim(32'h0000_5A32);
    run_req(2, 0, 30, 0, 0, '0, "R4 truncating");
    run_req(2, 0, 10, 0, 0, '0, "R4 below P1");
    run_req(2, 1, 41, 0, 0, '0, "R5 negative truncation");
    run_req(2, 1, 200, 0, 0, '0, "R5 high code");
    run_req(1, 1, 10, 0, 0, '0, "R6 one-point code");
    run_req(1, 0, 200, 0, 0, '0, "R6 one-point temp");
    run_req(0, 0, 100, 0, 0, '0, "R7 mode 00 temp");
    run_req(3, 1, 40, 0, 0, '0, "R7 mode 11 code");

    // R8 inclusive bounds
    run_req(1, 0, 24, 1, 0, '0, "R8 temp low out");
    run_req(1, 0, 25, 1, 0, '0, "R8 temp low in");
    run_req(1, 0, 125, 1, 0, '0, "R8 temp high in");
    run_req(1, 0, 126, 1, 0, '0, "R8 temp high out");
    run_req(1, 1, 74, 1, 0, '0, "R8 code low out");
    run_req(1, 1, 75, 1, 0, '0, "R8 code low in");
    run_req(1, 1, 175, 1, 0, '0, "R8 code high in");
    run_req(1, 1, 176, 1, 0, '0, "R8 code high out");

    // R9 equal trim codes
    load_trim(32'h0000_3C3C);
    run_req(2, 1, 100, 0, 0, '0, "R9 divide by zero");
    run_req(2, 0, 100, 0, 0, '0, "R9 flat slope ok");

    // R11 reload during a conversion
    load_trim(32'h0000_5A32);
    run_req(1, 0, 25, 0, 1, 32'h0000_7346, "R11 in-flight unchanged");
    run_req(1, 0, 25, 0, 0, '0, "R11 next uses new trim");

    // random mix across all requirements
    for (int i = 0; i < 300; i++) begin
      if ($urandom_range(0, 4) == 0) load_trim($urandom());
      run_req(int'($urandom_range(0, 3)), int'($urandom_range(0, 1)),
              int'($urandom_range(0, 255)), int'($urandom_range(0, 3) == 0),
              $urandom_range(0, 9) == 0, $urandom(), "R4-mix random");
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL R10 watchdog expired actual 0 expected 1");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule